// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the combinational arithmetic and logic unit of a small accumulator processor with an 8-bit datapath. Each cycle it takes the accumulator, the X index register, one operand byte, a 4-bit operation code and the current status byte. It returns the next accumulator or memory result, the next X value and the next status byte. The surrounding core decodes instructions, holds the registers and performs memory access. This unit only computes.

Each operation writes only the status flags it owns. All other status bits leave exactly as they arrived. Subtract and compare treat carry as "no borrow". Bit test copies the two top operand bits straight into the flags. One non-standard operation subtracts the operand from the AND of the accumulator and X, and writes the difference into X.

For every operation, res_out carries the accumulator unchanged unless the operation states otherwise. A status byte uses N = bit 7, V = bit 6, Z = bit 1 and C = bit 0. N is always the top bit of the value a flag rule names, and Z is set when that value is zero.

Top module: `acc_alu`

## Requirements
- R1: ADD (op_sel 1) forms A + operand + C. res_out is the low 8 bits. C becomes bit 8 of the sum. V is set when A and the operand share a sign and the result's sign differs from A. N and Z follow the result.
- R2: SUB (op_sel 2) forms A − operand − (1 − C). res_out is the low 8 bits. C is set when no borrow occurred. V is set when A and the operand differ in sign and the result's sign differs from A. N and Z follow the result.
- R3: The compares CMPA (op_sel 3, register A) and CMPX (op_sel 4, register X) form register − operand. N and Z come from the low 8 bits, and C is set when there is no borrow. V, res_out (= A) and x_out (= X) are unchanged.
- R4: BIT (op_sel 8) sets Z when A AND operand is zero. It copies operand bit 7 into N and operand bit 6 into V. C is kept and res_out equals A.
- R5: SHL (op_sel 9) returns the operand shifted left with a zero fill, and moves operand bit 7 into C. SHR (op_sel 10) shifts right with a zero fill, moves operand bit 0 into C and always clears N. N and Z follow the result. V is kept.
- R6: ROL (op_sel 11) shifts the operand left with the old C in bit 0, and bit 7 goes to C. ROR (op_sel 12) shifts right with the old C in bit 7, and bit 0 goes to C. N and Z follow the result. V is kept.
- R7: AXS (op_sel 15) forms (A AND X) − operand. x_out is the low 8 bits of the difference. N, Z and C are set as for a compare. V is kept and res_out equals A.
- R8: LOAD (0, result = operand), AND (5), OR (6), XOR (7), INC (13, operand + 1) and DEC (14, operand − 1) put their result on res_out. They update only N and Z, and keep V and C.
- R9: Status bits 5 down to 2 pass from stat_in to stat_out unchanged for every operation.
- R10: x_out equals x_in for every operation other than AXS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 8 | Accumulator value |
| x_in | input | 8 | X index register value |
| opnd_in | input | 8 | Operand byte (immediate or memory) |
| op_sel | input | 4 | Operation code, see requirements |
| stat_in | input | 8 | Current status byte (N=7, V=6, Z=1, C=0) |
| res_out | output | 8 | Accumulator or memory result |
| x_out | output | 8 | Next X value |
| stat_out | output | 8 | Next status byte |

## Verification
On every evaluation, immediate assertions check the following:
- the reserved status bits pass through;
- X is kept except for AXS;
- V is kept across the compares;
- bit test copies N and V from the operand;
- a logical right shift clears N;
- operations that own only N and Z keep V and C;
- the ADD carry relation holds.

The exact subtract borrow and overflow rules, the carry paths of rotate and shift, and the compare results need the bench. The bench sweeps every operation over all operands, with both carry-in values, against an independent model, and adds a table of hand-worked corner cases.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [3:0] {
      OP_LOAD = 4'd0,
      OP_ADD  = 4'd1,
      OP_SUB  = 4'd2,
      OP_CMPA = 4'd3,
      OP_CMPX = 4'd4,
      OP_AND  = 4'd5,
      OP_OR   = 4'd6,
      OP_XOR  = 4'd7,
      OP_BITT = 4'd8,
      OP_SHL  = 4'd9,
      OP_SHR  = 4'd10,
      OP_ROL  = 4'd11,
      OP_ROR  = 4'd12,
      OP_INC  = 4'd13,
      OP_DEC  = 4'd14,
      OP_AXS  = 4'd15
   } alu_op_e;

   localparam int ST_W = 8;
   localparam int FL_N = 7;
   localparam int FL_V = 6;
   localparam int FL_Z = 1;
   localparam int FL_C = 0;

   // which flags an operation is allowed to write
   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } flag_own_t;

   function automatic flag_own_t flags_owned(alu_op_e op);
      flag_own_t f;
      f = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
      case (op)
         OP_ADD, OP_SUB:                   f = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
         OP_CMPA, OP_CMPX, OP_AXS:         f = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
         OP_BITT:                          f = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
         OP_SHL, OP_SHR, OP_ROL, OP_ROR:   f = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
         default:                          f = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
      endcase
      return f;
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] lhs,
   input  logic [W-1:0] rhs,
   input  logic         sub_mode,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   logic [W-1:0] rhs_eff;

   assign rhs_eff = sub_mode ? ~rhs : rhs;

   generate
      if (W < 2) begin : g_bad_width
         $error("alu_addsub: W must be at least 2");
      end
      if (RIPPLE) begin : g_ripple
         logic [W:0]   cy;
         logic [W-1:0] s;
         assign cy[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign s[i]    = lhs[i] ^ rhs_eff[i] ^ cy[i];
            assign cy[i+1] = (lhs[i] & rhs_eff[i]) | (cy[i] & (lhs[i] ^ rhs_eff[i]));
         end
         assign sum  = s;
         assign cout = cy[W];
      end else begin : g_flat
         assign {cout, sum} = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, cin};
      end
   endgenerate

   // signed overflow: like-signed inputs, result sign flips
   assign ovf = (lhs[W-1] == rhs_eff[W-1]) && (sum[W-1] != lhs[W-1]);

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic [W-1:0] acc,
   input  logic [W-1:0] opnd,
   output logic [W-1:0] r
);
   always_comb begin
      case (op)
         OP_AND, OP_BITT: r = acc & opnd;
         OP_OR:           r = acc | opnd;
         OP_XOR:          r = acc ^ opnd;
         default:         r = opnd;
      endcase
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e      op,
   input  logic [W-1:0] opnd,
   input  logic         cin,
   output logic [W-1:0] r,
   output logic         cout
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   always_comb begin
      r    = opnd;
      cout = cin;
      case (op)
         OP_SHL: begin r = {opnd[W-2:0], 1'b0}; cout = opnd[W-1]; end
         OP_SHR: begin r = {1'b0, opnd[W-1:1]}; cout = opnd[0];   end
         OP_ROL: begin r = {opnd[W-2:0], cin};  cout = opnd[W-1]; end
         OP_ROR: begin r = {cin, opnd[W-1:1]};  cout = opnd[0];   end
         OP_INC: r = opnd + ONE;
         OP_DEC: r = opnd - ONE;
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0]    a_in,
   input  logic [W-1:0]    x_in,
   input  logic [W-1:0]    opnd_in,
   input  logic [3:0]      op_sel,
   input  logic [ST_W-1:0] stat_in,
   output logic [W-1:0]    res_out,
   output logic [W-1:0]    x_out,
   output logic [ST_W-1:0] stat_out
);
   generate
      if (W < 2) begin : g_bad_width
         $error("acc_alu: W must be at least 2");
      end
   endgenerate

   alu_op_e opc;
   assign opc = alu_op_e'(op_sel);

   // adder operand steering
   logic [W-1:0] add_lhs, add_sum, log_r, sh_r;
   logic         add_sub, add_cin, add_cout, add_ovf, sh_cout;

   always_comb begin
      case (opc)
         OP_CMPX: add_lhs = x_in;
         OP_AXS:  add_lhs = a_in & x_in;
         default: add_lhs = a_in;
      endcase
      add_sub = (opc != OP_ADD);
      add_cin = (opc == OP_ADD || opc == OP_SUB) ? stat_in[FL_C] : 1'b1;
   end

   alu_addsub #(.W(W), .RIPPLE(RIPPLE)) u_addsub (
      .lhs      (add_lhs),
      .rhs      (opnd_in),
      .sub_mode (add_sub),
      .cin      (add_cin),
      .sum      (add_sum),
      .cout     (add_cout),
      .ovf      (add_ovf)
   );

   alu_bitwise #(.W(W)) u_bitwise (
      .op   (opc),
      .acc  (a_in),
      .opnd (opnd_in),
      .r    (log_r)
   );

   alu_shifter #(.W(W)) u_shifter (
      .op   (opc),
      .opnd (opnd_in),
      .cin  (stat_in[FL_C]),
      .r    (sh_r),
      .cout (sh_cout)
   );

   // result and candidate flag values
   logic [W-1:0] flag_src;
   logic         new_v, new_c;
   flag_own_t    own;

   always_comb begin
      res_out  = a_in;
      x_out    = x_in;
      flag_src = add_sum;
      new_v    = add_ovf;
      new_c    = add_cout;
      case (opc)
         OP_ADD, OP_SUB: res_out = add_sum;
         OP_CMPA, OP_CMPX: ;
         OP_AXS: x_out = add_sum;
         OP_BITT: begin
            flag_src = log_r;
            new_v    = opnd_in[W-2];
         end
         OP_LOAD, OP_AND, OP_OR, OP_XOR: begin
            res_out  = log_r;
            flag_src = log_r;
         end
         default: begin
            res_out  = sh_r;
            flag_src = sh_r;
            new_c    = sh_cout;
         end
      endcase
   end

   assign own = flags_owned(opc);

   always_comb begin
      stat_out = stat_in;
      if (own.n) stat_out[FL_N] = (opc == OP_BITT) ? opnd_in[W-1] : flag_src[W-1];
      if (own.v) stat_out[FL_V] = new_v;
      if (own.z) stat_out[FL_Z] = (flag_src == '0);
      if (own.c) stat_out[FL_C] = new_c;
   end

   // ---------------- assertions ----------------
   always_comb begin
      // R9
      stat_pass_chk: assert (stat_out[5:2] == stat_in[5:2])
         else $error("reserved status bits altered");
      // R10
      x_keep_chk: assert (opc == OP_AXS || x_out == x_in)
         else $error("X altered by non-AXS op");
      // R3
      cmp_v_chk: assert (!(opc inside {OP_CMPA, OP_CMPX, OP_AXS}) ||
                         (stat_out[FL_V] == stat_in[FL_V] && res_out == a_in))
         else $error("compare touched V or A");
      // R4
      bit_copy_chk: assert (opc != OP_BITT ||
                            (stat_out[FL_N] == opnd_in[W-1] && stat_out[FL_V] == opnd_in[W-2] &&
                             stat_out[FL_C] == stat_in[FL_C] && res_out == a_in))
         else $error("bit test flags wrong");
      // R5
      shr_n_chk: assert (opc != OP_SHR || !stat_out[FL_N])
         else $error("logical shift right left N set");
      // R8
      nz_only_chk: assert (!(opc inside {OP_LOAD, OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC}) ||
                           (stat_out[FL_V] == stat_in[FL_V] && stat_out[FL_C] == stat_in[FL_C]))
         else $error("N/Z-only op changed V or C");
      // R1
      add_carry_chk: assert (opc != OP_ADD ||
                             {stat_out[FL_C], res_out} ==
                             (W+1)'(a_in) + (W+1)'(opnd_in) + (W+1)'(stat_in[FL_C]))
         else $error("add carry/sum mismatch");
   end

endmodule

// File: tb/tb_acc_alu.sv
`timescale 1ns/1ps
module tb_acc_alu;

   logic       clk = 1'b0;
   logic [7:0] a_in = '0, x_in = '0, opnd_in = '0, stat_in = '0;
   logic [3:0] op_sel = '0;
   logic [7:0] res_out, x_out, stat_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   acc_alu dut (
      .a_in(a_in), .x_in(x_in), .opnd_in(opnd_in), .op_sel(op_sel),
      .stat_in(stat_in), .res_out(res_out), .x_out(x_out), .stat_out(stat_out)
   );

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3, 4'd4: return "R3";
         4'd8: return "R4";
         4'd9, 4'd10: return "R5";
         4'd11, 4'd12: return "R6";
         4'd15: return "R7";
         default: return "R8";
      endcase
   endfunction

   // independent model written from the requirements: {res, x, stat}
   function automatic logic [23:0] model(input logic [3:0] op, input logic [7:0] a,
                                         input logic [7:0] x, input logic [7:0] m,
                                         input logic [7:0] s);
      logic [8:0] t;
      logic [7:0] r, xo, so, v;
      r = a; xo = x; so = s; v = 8'h00;
      t = 9'h000;
      case (op)
         4'd1: begin
            t = {1'b0, a} + {1'b0, m} + {8'h00, s[0]};
            r = t[7:0]; so[0] = t[8];
            so[6] = (a[7] == m[7]) && (r[7] != a[7]); v = r;
         end
         4'd2: begin
            t = {1'b0, a} - {1'b0, m} - {8'h00, ~s[0]};
            r = t[7:0]; so[0] = ~t[8];
            so[6] = (a[7] != m[7]) && (r[7] != a[7]); v = r;
         end
         4'd3: begin t = {1'b0, a} - {1'b0, m}; so[0] = ~t[8]; v = t[7:0]; end
         4'd4: begin t = {1'b0, x} - {1'b0, m}; so[0] = ~t[8]; v = t[7:0]; end
         4'd15: begin
            t = {1'b0, a & x} - {1'b0, m}; so[0] = ~t[8]; v = t[7:0]; xo = t[7:0];
         end
         4'd8: v = a & m;
         4'd0: begin r = m; v = r; end
         4'd5: begin r = a & m; v = r; end
         4'd6: begin r = a | m; v = r; end
         4'd7: begin r = a ^ m; v = r; end
         4'd13: begin r = m + 8'd1; v = r; end
         4'd14: begin r = m - 8'd1; v = r; end
         4'd9:  begin r = m << 1; so[0] = m[7]; v = r; end
         4'd10: begin r = m >> 1; so[0] = m[0]; v = r; end
         4'd11: begin r = {m[6:0], s[0]}; so[0] = m[7]; v = r; end
         default: begin r = {s[0], m[7:1]}; so[0] = m[0]; v = r; end
      endcase
      so[1] = (v == 8'h00);
      so[7] = v[7];
      if (op == 4'd8) begin so[7] = m[7]; so[6] = m[6]; end
      return {r, xo, so};
   endfunction

   task automatic check(input string tag, input logic [23:0] exp);
      n_tests++;
      if ({res_out, x_out, stat_out} !== exp) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%h x=%h m=%h s=%h : got res=%h x=%h st=%h exp res=%h x=%h st=%h",
                  tag, op_sel, a_in, x_in, opnd_in, stat_in, res_out, x_out, stat_out,
                  exp[23:16], exp[15:8], exp[7:0]);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] x,
                        input logic [7:0] m, input logic [7:0] s);
      op_sel = op; a_in = a; x_in = x; opnd_in = m; stat_in = s;
      #1;
   endtask

   // {op, a, x, m, s, exp_res, exp_x, exp_stat}
   localparam int NV = 12;
   localparam logic [59:0] VEC [NV] = '{
      {4'd1,  8'h50, 8'h00, 8'h50, 8'h00, 8'hA0, 8'h00, 8'hC0}, // R1 overflow
      {4'd1,  8'hFF, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h01}, // R1 carry out
      {4'd2,  8'h00, 8'h00, 8'h01, 8'h01, 8'hFF, 8'h00, 8'h80}, // R2 borrow
      {4'd2,  8'h80, 8'h00, 8'h01, 8'h01, 8'h7F, 8'h00, 8'h41}, // R2 overflow
      {4'd3,  8'h40, 8'h00, 8'h40, 8'h40, 8'h40, 8'h00, 8'h43}, // R3 equal, V kept
      {4'd8,  8'h01, 8'h00, 8'hC0, 8'h00, 8'h01, 8'h00, 8'hC2}, // R4
      {4'd10, 8'h00, 8'h00, 8'h01, 8'h80, 8'h00, 8'h00, 8'h03}, // R5 SHR clears N
      {4'd12, 8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 8'h00, 8'h81}, // R6 ROR
      {4'd15, 8'hF0, 8'h3C, 8'h30, 8'h00, 8'hF0, 8'h00, 8'h03}, // R7
      {4'd14, 8'h00, 8'h00, 8'h00, 8'h7D, 8'hFF, 8'h00, 8'hFD}, // R8 DEC wrap, R9
      {4'd13, 8'h00, 8'h00, 8'hFF, 8'h80, 8'h00, 8'h00, 8'h02}, // R8 INC wrap
      {4'd9,  8'h00, 8'h00, 8'h80, 8'h3C, 8'h00, 8'h00, 8'h3F}  // R5 SHL, R9
   };

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      // initial state: LOAD of zero sets only Z
      apply(4'd0, 8'h00, 8'h00, 8'h00, 8'h00);
      check("R8", {8'h00, 8'h00, 8'h02});

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][59:56], VEC[i][55:48], VEC[i][47:40], VEC[i][39:32], VEC[i][31:24]);
         check(tag_of(VEC[i][59:56]), VEC[i][23:0]);
      end

      // directed: R10 X kept across AND with X nonzero
      apply(4'd5, 8'hF0, 8'hA5, 8'h3C, 8'h00);
      check("R10", {8'h30, 8'hA5, 8'h00});
      // directed: R6 ROL carry in and out
      apply(4'd11, 8'h00, 8'h00, 8'h80, 8'h01);
      check("R6", {8'h01, 8'h00, 8'h01});
      // directed: R3 CMPX below operand clears C
      apply(4'd4, 8'h77, 8'h10, 8'h20, 8'h01);
      check("R3", {8'h77, 8'h10, 8'h80});
      // directed: R9 reserved bits kept through ADD
      apply(4'd1, 8'h01, 8'h00, 8'h01, 8'h3C);
      check("R9", {8'h02, 8'h00, 8'h3C});

      // sweep: every op, sampled A, all operands, both carry-in values
      for (int op = 0; op < 16; op++) begin
         for (int ai = 0; ai < 16; ai++) begin
            for (int m = 0; m < 256; m++) begin
               for (int c = 0; c < 2; c++) begin
                  logic [7:0] av, xv, sv;
                  av = 8'(ai * 17);
                  xv = av ^ 8'h5A;
                  sv = {4'(m), 1'b0, 2'(ai), 1'(c)} ^ 8'h3C;
                  apply(4'(op), av, xv, 8'(m), sv);
                  check(tag_of(4'(op)), model(4'(op), av, xv, 8'(m), sv));
               end
            end
         end
      end

      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

endmodule